// File: doc/BRIEF.md
# Status LED Multiplexer

This block decides what six indicator LEDs on a board show. Each LED either follows a bit of a remote override bus, when that bus is flagged active, or follows local status. The local status is a slow blink while the main supply request is off, a steady or forwarded signal once the supply is requested, and a pulse-count pattern that tells the selected boot mode. The outputs are a green LED, a red LED and two two-wire (bicolour) LED pairs. One pair shows power and the other shows disk activity.

Two generators run inside the block. The first is a free-running slow blink that toggles every half period. The second is a mode blink state machine with three states. **PAUSE** holds the pattern low. When its timer expires it takes the transition *start_burst* to **PULSE**, which samples the boot mode and clears the pulse count. **PULSE** drives the pattern high. When its timer expires it takes *end_pulse* to **GAP** and counts one pulse. **GAP** holds the pattern low. When its timer expires it takes *next_pulse* back to **PULSE** if more pulses are due, or *end_burst* to **PAUSE** once the count reaches the boot mode plus one. Reset places the machine in **PAUSE**. A routing stage then applies the priority rule of each LED.

Top module: `led_status_mux`

## Requirements
- R1: While `ovr_active` is 1, `led_green` equals `ovr_bus[5]`.
- R2: While `ovr_active` is 0, `led_green` equals the slow blink when `supply_req` is 0, and is 1 when `supply_req` is 1.
- R3: `led_red` equals `ovr_bus[6]` while `ovr_active` is 1. Otherwise it is 1 when `rst_btn_n` is 0 (button pressed) or when the mode blink is high.
- R4: `pwr_led_p` equals the inverse of `ovr_bus[8]` while `ovr_active` is 1. Otherwise it equals the slow blink when `supply_req` is 0, and `cpu_led` when `supply_req` is 1.
- R5: `pwr_led_n` equals `ovr_bus[7]` and `disk_led_n` equals `ovr_bus[9]` while `ovr_active` is 1. Both are 0 otherwise.
- R6: `disk_led_p` equals the inverse of `ovr_bus[10]` while `ovr_active` is 1, and equals `fab_led` otherwise.
- R7: The slow blink is 0 from reset. It toggles on every `BLINK_HALF`-th rising clock edge after reset is released. The default of 12,288,000 gives a 0.5 s half period at 24.576 MHz.
- R8: After reset the mode blink stays low for `PAUSE_CYC` cycles. It then repeats a burst of `boot_mode`+1 pulses, each pulse `PULSE_CYC` cycles high followed by `PULSE_CYC` cycles low, and each burst is followed by `PAUSE_CYC` low cycles.
- R9: `boot_mode` is sampled only at the edge where a burst starts. A change during a burst or a pause has no effect until the next burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (24.576 MHz by default) |
| rst_n | input | 1 | Asynchronous reset, active low |
| ovr_bus | input | OVR_W (11) | Remote override bits; bits 5 to 10 are used |
| ovr_active | input | 1 | Override bus is valid and takes priority |
| supply_req | input | 1 | Main supply request; 0 means the supply is off |
| rst_btn_n | input | 1 | Reset button, 0 when pressed |
| boot_mode | input | MODE_W (2) | Boot mode index shown by the mode blink |
| cpu_led | input | 1 | LED line from the processor |
| fab_led | input | 1 | LED line from the logic fabric |
| led_green | output | 1 | Green status LED |
| led_red | output | 1 | Red status LED |
| pwr_led_p | output | 1 | Power LED pair, positive leg |
| pwr_led_n | output | 1 | Power LED pair, negative leg |
| disk_led_p | output | 1 | Disk LED pair, positive leg |
| disk_led_n | output | 1 | Disk LED pair, negative leg |

## Verification
The bench runs the block with the override inactive and the supply off, so that the two LEDs driven by the slow blink can be told apart from the forwarded lines. It then turns the supply on and toggles the processor and fabric lines, which separates the steady-on green path from the forwarded paths. Walking and alternating patterns are applied to the override bus to show which bit drives which LED and where an inversion applies. The boot mode is changed in the middle of bursts and the reset button is pressed, so the pulse count and the sampling point of the mode blink are checked against a queue-based model.

// File: rtl/led_status_pkg.sv
package led_status_pkg;

    // Override bus bit positions decoded by the remote side
    localparam int OVR_GREEN_BIT   = 5;
    localparam int OVR_RED_BIT     = 6;
    localparam int OVR_PWR_N_BIT   = 7;
    localparam int OVR_PWR_P_BIT   = 8;
    localparam int OVR_DISK_N_BIT  = 9;
    localparam int OVR_DISK_P_BIT  = 10;
    localparam int OVR_MIN_W       = 11;

    typedef enum logic [1:0] {
        MB_PAUSE = 2'd0,
        MB_PULSE = 2'd1,
        MB_GAP   = 2'd2
    } mblink_state_e;

endpackage

// File: rtl/slow_blink_gen.sv
module slow_blink_gen #(
    parameter int BLINK_HALF = 12_288_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic blink
);
    localparam int CW = $clog2(BLINK_HALF + 1);
    localparam logic [CW-1:0] LIMIT = CW'(BLINK_HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          blink_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            blink_q <= 1'b0;
        end else if (cnt_q == LIMIT) begin
            cnt_q   <= '0;
            blink_q <= ~blink_q;
        end else begin
            cnt_q   <= cnt_q + CW'(1);
        end
    end

    assign blink = blink_q;
endmodule

// File: rtl/mode_blink_fsm.sv
module mode_blink_fsm
    import led_status_pkg::*;
#(
    parameter int MODE_W    = 2,
    parameter int PULSE_CYC = 2_457_600,
    parameter int PAUSE_CYC = 12_288_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] boot_mode,
    output logic              blink,
    output mblink_state_e     state
);
    localparam int MAXD = (PULSE_CYC > PAUSE_CYC) ? PULSE_CYC : PAUSE_CYC;
    localparam int TW   = $clog2(MAXD + 1);
    localparam int NW   = MODE_W + 1;
    localparam logic [TW-1:0] PULSE_LIM = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] PAUSE_LIM = TW'(PAUSE_CYC - 1);

    mblink_state_e     state_q, state_d;
    logic [TW-1:0]     tmr_q;
    logic [NW-1:0]     npulse_q;
    logic [MODE_W-1:0] mode_q;
    logic              expired;
    logic              burst_done;

    always_comb begin
        expired    = (state_q == MB_PAUSE) ? (tmr_q == PAUSE_LIM) : (tmr_q == PULSE_LIM);
        burst_done = (npulse_q == ({1'b0, mode_q} + NW'(1)));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MB_PAUSE: if (expired) state_d = MB_PULSE;                        // start_burst
            MB_PULSE: if (expired) state_d = MB_GAP;                          // end_pulse
            MB_GAP:   if (expired) state_d = burst_done ? MB_PAUSE : MB_PULSE; // end_burst / next_pulse
            default:  state_d = MB_PAUSE;
        endcase
    end

    // state register with timer, pulse count and sampled mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= MB_PAUSE;
            tmr_q    <= '0;
            npulse_q <= '0;
            mode_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= expired ? '0 : tmr_q + TW'(1);
            if (state_q == MB_PAUSE && expired) begin
                mode_q   <= boot_mode;
                npulse_q <= '0;
            end else if (state_q == MB_PULSE && expired) begin
                npulse_q <= npulse_q + NW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            MB_PULSE: blink = 1'b1;
            default:  blink = 1'b0;
        endcase
        state = state_q;
    end
endmodule

// File: rtl/led_route.sv
module led_route
    import led_status_pkg::*;
#(
    parameter int OVR_W = 11
) (
    input  logic [OVR_W-1:0] ovr_bus,
    input  logic             ovr_active,
    input  logic             supply_req,
    input  logic             rst_btn_n,
    input  logic             cpu_led,
    input  logic             fab_led,
    input  logic             slow_blink,
    input  logic             mode_blink,
    output logic             led_green,
    output logic             led_red,
    output logic             pwr_led_p,
    output logic             pwr_led_n,
    output logic             disk_led_p,
    output logic             disk_led_n
);
    logic off_blink_green;
    logic off_blink_pwr;

    always_comb begin
        off_blink_green = supply_req ? 1'b1    : slow_blink;
        off_blink_pwr   = supply_req ? cpu_led : slow_blink;

        if (ovr_active) begin
            led_green  =  ovr_bus[OVR_GREEN_BIT];
            led_red    =  ovr_bus[OVR_RED_BIT];
            pwr_led_p  = ~ovr_bus[OVR_PWR_P_BIT];
            pwr_led_n  =  ovr_bus[OVR_PWR_N_BIT];
            disk_led_p = ~ovr_bus[OVR_DISK_P_BIT];
            disk_led_n =  ovr_bus[OVR_DISK_N_BIT];
        end else begin
            led_green  = off_blink_green;
            led_red    = ~rst_btn_n | mode_blink;
            pwr_led_p  = off_blink_pwr;
            pwr_led_n  = 1'b0;
            disk_led_p = fab_led;
            disk_led_n = 1'b0;
        end
    end
endmodule

// File: rtl/led_status_mux.sv
module led_status_mux
    import led_status_pkg::*;
#(
    parameter int OVR_W      = 11,
    parameter int MODE_W     = 2,
    parameter int BLINK_HALF = 12_288_000,
    parameter int PULSE_CYC  = 2_457_600,
    parameter int PAUSE_CYC  = 12_288_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OVR_W-1:0]  ovr_bus,
    input  logic              ovr_active,
    input  logic              supply_req,
    input  logic              rst_btn_n,
    input  logic [MODE_W-1:0] boot_mode,
    input  logic              cpu_led,
    input  logic              fab_led,
    output logic              led_green,
    output logic              led_red,
    output logic              pwr_led_p,
    output logic              pwr_led_n,
    output logic              disk_led_p,
    output logic              disk_led_n
);
    logic          slow_blink;
    logic          mode_blink;
    mblink_state_e mb_state;

    slow_blink_gen #(.BLINK_HALF(BLINK_HALF)) u_slow (
        .clk   (clk),
        .rst_n (rst_n),
        .blink (slow_blink)
    );

    mode_blink_fsm #(
        .MODE_W    (MODE_W),
        .PULSE_CYC (PULSE_CYC),
        .PAUSE_CYC (PAUSE_CYC)
    ) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_mode (boot_mode),
        .blink     (mode_blink),
        .state     (mb_state)
    );

    led_route #(.OVR_W(OVR_W)) u_route (
        .ovr_bus    (ovr_bus),
        .ovr_active (ovr_active),
        .supply_req (supply_req),
        .rst_btn_n  (rst_btn_n),
        .cpu_led    (cpu_led),
        .fab_led    (fab_led),
        .slow_blink (slow_blink),
        .mode_blink (mode_blink),
        .led_green  (led_green),
        .led_red    (led_red),
        .pwr_led_p  (pwr_led_p),
        .pwr_led_n  (pwr_led_n),
        .disk_led_p (disk_led_p),
        .disk_led_n (disk_led_n)
    );
endmodule

// File: rtl/led_status_chk.sv
module led_status_chk
    import led_status_pkg::*;
#(
    parameter int OVR_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OVR_W-1:0] ovr_bus,
    input logic             ovr_active,
    input logic             supply_req,
    input logic             rst_btn_n,
    input logic             led_green,
    input logic             led_red,
    input logic             pwr_led_n,
    input logic             disk_led_n,
    input logic             slow_blink,
    input logic             mode_blink,
    input mblink_state_e    mb_state
);
    // R1: override wins for green
    a_r1_green_override: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_active |-> led_green == ovr_bus[OVR_GREEN_BIT]);

    // R2: supply requested and no override gives steady green
    a_r2_green_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_active && supply_req) |-> led_green);

    // R3: pressed button lights red when not overridden
    a_r3_red_button: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_active && !rst_btn_n) |-> led_red);

    // R5: negative legs idle when not overridden
    a_r5_neg_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_active |-> (!pwr_led_n && !disk_led_n));

    // R8: a burst always starts with a pulse after a pause
    a_r8_pause_to_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_state == MB_PAUSE) |=> (mb_state != MB_GAP));

    // R8: pulse is followed by a pulse or a gap, never a pause
    a_r8_pulse_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_state == MB_PULSE) |=> (mb_state != MB_PAUSE));

    // R7: the slow blink only changes on a clocked toggle
    a_r7_blink_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slow_blink) |=> slow_blink);
endmodule

bind led_status_mux led_status_chk #(.OVR_W(OVR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovr_bus    (ovr_bus),
    .ovr_active (ovr_active),
    .supply_req (supply_req),
    .rst_btn_n  (rst_btn_n),
    .led_green  (led_green),
    .led_red    (led_red),
    .pwr_led_n  (pwr_led_n),
    .disk_led_n (disk_led_n),
    .slow_blink (slow_blink),
    .mode_blink (mode_blink),
    .mb_state   (mb_state)
);

// File: tb/led_status_mux_tb.sv
module led_status_mux_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int OVR_W      = 11;
    localparam int MODE_W     = 2;
    localparam int HALF       = 40;
    localparam int PULSE      = 3;
    localparam int PAUSE      = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [OVR_W-1:0]  ovr_bus = '0;
    logic              ovr_active = 1'b0;
    logic              supply_req = 1'b0;
    logic              rst_btn_n = 1'b1;
    logic [MODE_W-1:0] boot_mode = '0;
    logic              cpu_led = 1'b0;
    logic              fab_led = 1'b0;
    logic led_green, led_red, pwr_led_p, pwr_led_n, disk_led_p, disk_led_n;

    int checks = 0;
    int errors = 0;

    led_status_mux #(
        .OVR_W(OVR_W), .MODE_W(MODE_W), .BLINK_HALF(HALF),
        .PULSE_CYC(PULSE), .PAUSE_CYC(PAUSE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ovr_bus(ovr_bus), .ovr_active(ovr_active),
        .supply_req(supply_req), .rst_btn_n(rst_btn_n), .boot_mode(boot_mode),
        .cpu_led(cpu_led), .fab_led(fab_led),
        .led_green(led_green), .led_red(led_red), .pwr_led_p(pwr_led_p),
        .pwr_led_n(pwr_led_n), .disk_led_p(disk_led_p), .disk_led_n(disk_led_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model: edge counter for the slow blink, pattern queue for the mode blink
    int   edges_since_rst = 0;
    bit   pat_q[$];
    bit   started = 1'b0;

    function automatic void load_pause();
        for (int i = 0; i < PAUSE; i++) pat_q.push_back(1'b0);
    endfunction

    function automatic void load_burst(int mode);
        for (int p = 0; p <= mode; p++) begin
            for (int i = 0; i < PULSE; i++) pat_q.push_back(1'b1);
            for (int i = 0; i < PULSE; i++) pat_q.push_back(1'b0);
        end
        load_pause();
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            edges_since_rst = 0;
            pat_q.delete();
            load_pause();
            started = 1'b1;
        end else begin
            edges_since_rst++;
            void'(pat_q.pop_front());
            if (pat_q.size() == 0) load_burst(int'(boot_mode));
        end
    end

    task automatic check1(string req, string nm, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, nm, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            logic sb, mb;
            sb = rst_n ? (((edges_since_rst / HALF) % 2) == 1) : 1'b0;
            mb = rst_n ? pat_q[0] : 1'b0;
            if (ovr_active) begin
                check1("R1", "led_green",  led_green,  ovr_bus[5]);
                check1("R3", "led_red",    led_red,    ovr_bus[6]);
                check1("R4", "pwr_led_p",  pwr_led_p,  ~ovr_bus[8]);
                check1("R5", "pwr_led_n",  pwr_led_n,  ovr_bus[7]);
                check1("R5", "disk_led_n", disk_led_n, ovr_bus[9]);
                check1("R6", "disk_led_p", disk_led_p, ~ovr_bus[10]);
            end else begin
                // slow blink (R7) is seen on green/power; mode blink (R8, R9) on red
                check1("R2_R7", "led_green", led_green, supply_req ? 1'b1 : sb);
                check1("R3_R8_R9", "led_red", led_red, ~rst_btn_n | mb);
                check1("R4_R7", "pwr_led_p", pwr_led_p, supply_req ? cpu_led : sb);
                check1("R5", "pwr_led_n",  pwr_led_n,  1'b0);
                check1("R5", "disk_led_n", disk_led_n, 1'b0);
                check1("R6", "disk_led_p", disk_led_p, fab_led);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        // watchdog
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // supply off, mode 0: slow blink and single pulses (R2, R7, R8)
        boot_mode = 2'd0;
        step(200);
        // mode 3 picked at next burst; change it mid-burst later (R9)
        boot_mode = 2'd3;
        step(17);
        boot_mode = 2'd1;
        step(23);
        boot_mode = 2'd2;
        step(150);
        // supply on, forwarded lines (R2, R4, R6)
        supply_req = 1'b1;
        for (int i = 0; i < 40; i++) begin
            cpu_led = i[0];
            fab_led = i[1];
            step(3);
        end
        // reset button press (R3)
        rst_btn_n = 1'b0;
        step(30);
        rst_btn_n = 1'b1;
        supply_req = 1'b0;
        step(60);
        // override: walking one then alternating (R1, R3, R4, R5, R6)
        ovr_active = 1'b1;
        for (int b = 0; b < OVR_W; b++) begin
            ovr_bus = OVR_W'(1) << b;
            step(2);
        end
        ovr_bus = 11'b101_0101_0101;
        step(4);
        ovr_bus = 11'b010_1010_1010;
        step(4);
        ovr_bus = '0;
        step(4);
        ovr_active = 1'b0;
        boot_mode = 2'd3;
        step(120);
        // second reset mid-pattern
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(100);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule